// File: doc/BRIEF.md
# Multi-Format Serial Result Port

This block takes 16-bit results from a converter core and sends them to a host over one serial data pin. The core hands over a word in parallel with a one-cycle load strobe. An active-low ready flag tells the host that a word is waiting. The host pulls its active-low select line low to fetch the word. A static 2-bit mode input picks one of three line formats. The first is asynchronous framed characters. The second is a raw synchronous stream clocked by the host. The third is a raw synchronous stream whose bit clock the block generates itself from the master clock.

In the two host-clocked formats, the host's bit clock is synchronised into the master clock domain. The data pin changes after each falling edge of that clock, so the host samples on rising edges. In the self-clocked format, the block drives its own bit clock pin at a quarter of the master clock rate. That clock is high for one master cycle in four. The pin's output enable is asserted only in this format. Every load blanks the ready flag for a fixed number of master cycles. A load also takes priority over any transfer in progress.

Top module: `ser_out_port`

## Requirements
- R1: After reset, the ready flag `drdy_n` is 1, `sdata` idles at 1, and `sclk_oe` is 0 while `mode` is 2'b00.
- R2: With `mode`=2'b00, a word goes out as 22 bit times, one per falling edge of `sclk_in`. The upper byte is sent first, then the lower byte. Each byte is framed as: one start bit of 0, the 8 data bits LSB first, then two stop bits of 1.
- R3: With `mode`=2'b01, the 16 bits go out unframed, MSB first. Each bit is held until the next falling edge of `sclk_in`.
- R4: With `mode`=2'b10 or 2'b11, the 16 bits go out unframed and MSB first, clocked by `sclk_out`. `sdata` is stable while `sclk_out` is high.
- R5: In the self-clocked formats, `sclk_out` has a period of 4 master cycles and is high for exactly 1 of them.
- R6: When a word is waiting, its load blanking has ended, and `cs_n` is high, `drdy_n` is 0 and `sdata` stays at its idle level of 1.
- R7: Once the last bit time of a word ends, `drdy_n` returns to 1 and `sdata` returns to 1.
- R8: A load strobe holds `drdy_n` at 1 for exactly 4 master cycles after the capturing edge. `drdy_n` goes to 0 in the fifth cycle.
- R9: A load during a transfer ends that transfer at once and applies the same 4-cycle blanking. The next select then sends the new word from its first bit.
- R10: Raising `cs_n` in the middle of a word aborts it. `sdata` returns to 1, and `drdy_n` stays at 1 until the next load, even if `cs_n` falls again.
- R11: `sclk_oe` is 0 in `mode` 2'b00 and 2'b01. `sclk_out` is never high in those modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Line format: 00 framed async, 01 host-clocked sync, 1x self-clocked sync |
| load | input | 1 | One-cycle strobe that captures `load_data` |
| load_data | input | 16 | Result word from the converter core |
| cs_n | input | 1 | Active-low select from the host |
| sclk_in | input | 1 | Host bit clock (modes 00 and 01) |
| sclk_out | output | 1 | Generated bit clock (modes 10 and 11) |
| sclk_oe | output | 1 | Output enable for the bit clock pin |
| sdata | output | 1 | Serial data, idle high |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
A load strobe and a host deselect can land in the same master cycle while a word is halfway out. Load must win. The transfer must stop, the new word must be captured, and the 4-cycle blanking must run instead of the deselect's "no word" outcome. The bench sets this up in host-clocked mode: after three bits have gone out, it drives `load` high and `cs_n` high on the same falling clock edge. It then requires `drdy_n` to stay high for exactly four cycles and then fall, with `sdata` idle throughout. When select is lowered again, the new word must arrive complete from its MSB.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;
  typedef enum logic [1:0] {
    FMT_ASYNC    = 2'b00,
    FMT_EXT      = 2'b01,
    FMT_SELF     = 2'b10,
    FMT_SELF_ALT = 2'b11
  } fmt_e;

  localparam int START_BITS = 1;
  localparam int CHAR_DATA  = 8;
  localparam int STOP_BITS  = 2;
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sr[STAGES-1];

  assign fall = prev & ~sr[STAGES-1];
endmodule

// File: rtl/ser_quarter_clk.sv
module ser_quarter_clk #(
  parameter int DIV     = 4,
  parameter int HIGH_PH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic clk_lvl,
  output logic tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         phase <= '0;
    else if (!run)                      phase <= '0;
    else if (phase == PH_W'(DIV - 1))   phase <= '0;
    else                                phase <= phase + 1'b1;

  assign clk_lvl = run && (phase == PH_W'(HIGH_PH));
  assign tick    = run && (phase == PH_W'(DIV - 1));
endmodule

// File: rtl/ser_frame_ctl.sv
module ser_frame_ctl
  import ser_out_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              cs_n,
  input  logic              adv,
  output logic              busy,
  output logic              bit_out,
  output logic              drdy_n,
  output logic              start_evt,
  output logic              done_evt,
  output logic              abort_evt
);
  localparam int BYTES     = WORD_W / CHAR_DATA;
  localparam int CHAR_LEN  = START_BITS + CHAR_DATA + STOP_BITS;
  localparam int ASYNC_LEN = BYTES * CHAR_LEN;
  localparam int IDX_W     = $clog2(ASYNC_LEN + 1);
  localparam int HOLD_W    = $clog2(HOLD_CYC + 1);

  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic [HOLD_W-1:0] hold_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ready;
  logic              at_last;

  // bit number n of the frame in send order
  function automatic logic frame_bit(input fmt_e f, input logic [WORD_W-1:0] w,
                                     input logic [IDX_W-1:0] i);
    int n, ch, pos;
    n = int'(i);
    if (f == FMT_ASYNC) begin
      ch  = n / CHAR_LEN;
      pos = n % CHAR_LEN;
      if (pos < START_BITS)                  return 1'b0;
      else if (pos < START_BITS + CHAR_DATA) return w[(BYTES-1-ch)*CHAR_DATA + pos - START_BITS];
      else                                   return 1'b1;
    end
    return w[WORD_W-1-n];
  endfunction

  function automatic logic [IDX_W-1:0] frame_last(input fmt_e f);
    return (f == FMT_ASYNC) ? IDX_W'(ASYNC_LEN - 1) : IDX_W'(WORD_W - 1);
  endfunction

  assign ready   = valid_q && (hold_q == '0);
  assign at_last = (idx_q == frame_last(fmt));

  assign start_evt = !load && !busy && ready && !cs_n;
  assign abort_evt = !load && busy && cs_n;
  assign done_evt  = !load && busy && !cs_n && adv && at_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      hold_q  <= '0;
      busy    <= 1'b0;
      idx_q   <= '0;
    end else if (load) begin
      word_q  <= load_data;
      valid_q <= 1'b1;
      hold_q  <= HOLD_W'(HOLD_CYC);
      busy    <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      if (abort_evt || done_evt) begin
        busy    <= 1'b0;
        valid_q <= 1'b0;
      end else if (busy && adv) begin
        idx_q <= idx_q + 1'b1;
      end else if (start_evt) begin
        busy  <= 1'b1;
        idx_q <= '0;
      end
    end

  assign bit_out = busy ? frame_bit(fmt, word_q, idx_q) : 1'b1;
  assign drdy_n  = ~ready;
endmodule

// File: rtl/ser_out_port.sv
module ser_out_port
  import ser_out_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int HOLD_CYC  = 4,
  parameter int SYNC_STG  = 2,
  parameter int CLK_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              cs_n,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              sdata,
  output logic              drdy_n
);
  fmt_e fmt;
  logic is_self;
  logic ext_fall;
  logic q_lvl;
  logic q_tick;
  logic bit_adv;
  logic busy;
  logic start_evt;
  logic done_evt;
  logic abort_evt;

  assign fmt     = fmt_e'(mode);
  assign is_self = mode[1];

  ser_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sclk_in),
    .fall (ext_fall)
  );

  ser_quarter_clk #(.DIV(CLK_DIV), .HIGH_PH(1)) u_qclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy && is_self),
    .clk_lvl(q_lvl),
    .tick   (q_tick)
  );

  assign bit_adv = is_self ? q_tick : ext_fall;

  ser_frame_ctl #(.WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt),
    .load     (load),
    .load_data(load_data),
    .cs_n     (cs_n),
    .adv      (bit_adv),
    .busy     (busy),
    .bit_out  (sdata),
    .drdy_n   (drdy_n),
    .start_evt(start_evt),
    .done_evt (done_evt),
    .abort_evt(abort_evt)
  );

  assign sclk_out = q_lvl;
  assign sclk_oe  = is_self;
endmodule

// File: rtl/ser_out_port_chk.sv
module ser_out_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       load,
  input logic       cs_n,
  input logic       sclk_out,
  input logic       sclk_oe,
  input logic       sdata,
  input logic       drdy_n,
  input logic       busy,
  input logic       start_evt,
  input logic       done_evt,
  input logic       abort_evt
);
  // R8
  load_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> drdy_n);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (drdy_n && sdata));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && sdata && drdy_n));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_out) |=> !sclk_out);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out |-> sclk_oe);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mode == 2'b00) |-> !sdata);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_n && cs_n && !load && !busy) |=> !drdy_n);

  // R6
  start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && !drdy_n));
endmodule

bind ser_out_port ser_out_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .load     (load),
  .cs_n     (cs_n),
  .sclk_out (sclk_out),
  .sclk_oe  (sclk_oe),
  .sdata    (sdata),
  .drdy_n   (drdy_n),
  .busy     (busy),
  .start_evt(start_evt),
  .done_evt (done_evt),
  .abort_evt(abort_evt)
);

// File: tb/tb_ser_out_port.sv
module tb_ser_out_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        load = 1'b0;
  logic [15:0] load_data = '0;
  logic        cs_n = 1'b1;
  logic        sclk_in = 1'b0;
  logic        sclk_out, sclk_oe, sdata, drdy_n;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #4 clk = ~clk;

  ser_out_port dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .load(load), .load_data(load_data),
    .cs_n(cs_n), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdata(sdata), .drdy_n(drdy_n)
  );

  localparam int NVEC = 8;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b00, 16'hA5C3}, {2'b00, 16'h0000}, {2'b01, 16'h8001}, {2'b01, 16'hFFFF},
    {2'b10, 16'h1234}, {2'b10, 16'hF00F}, {2'b11, 16'h5A5A}, {2'b00, 16'hFFFF}
  };

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000 cycles", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk); load = 1'b1; load_data = w;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 20 && drdy_n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_frame(input logic [1:0] m, input logic [15:0] w,
                                              output int n);
    logic [31:0] e;
    logic [7:0]  b;
    e = '0;
    if (m == 2'b00) begin
      n = 22;
      for (int c = 0; c < 2; c++) begin
        b = (c == 0) ? w[15:8] : w[7:0];
        e[c*11] = 1'b0;
        for (int k = 0; k < 8; k++) e[c*11+1+k] = b[k];
        e[c*11+9]  = 1'b1;
        e[c*11+10] = 1'b1;
      end
    end else begin
      n = 16;
      for (int i = 0; i < 16; i++) e[i] = w[15-i];
    end
    return e;
  endfunction

  task automatic ext_capture(input int n, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[i] = sdata;
      sclk_in = 1'b1; tick(6);
      sclk_in = 1'b0; tick(6);
    end
  endtask

  task automatic self_capture(input int n, output logic [31:0] got, output logic timing_ok,
                              output int seen);
    int cyc, last;
    logic prev_hi;
    got = '0; timing_ok = 1'b1; seen = 0; cyc = 0; last = -1; prev_hi = 1'b0;
    while (seen < n && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (sclk_out) begin
        if (prev_hi) timing_ok = 1'b0;
        if (last >= 0 && cyc - last != 4) timing_ok = 1'b0;
        got[seen] = sdata;
        last = cyc;
        seen++;
      end
      prev_hi = sclk_out;
    end
  endtask

  initial begin
    logic [31:0] got, exp, mask;
    logic        tok;
    int          n, seen;

    tick(2);
    // R1 reset state
    chk(drdy_n == 1'b1, "R1 drdy in reset", 32'(drdy_n), 1);
    rst_n = 1'b1;
    tick(2);
    chk(drdy_n == 1'b1, "R1 drdy after reset", 32'(drdy_n), 1);
    chk(sdata == 1'b1, "R1 sdata idle", 32'(sdata), 1);
    chk(sclk_oe == 1'b0, "R1 sclk_oe", 32'(sclk_oe), 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      cs_n = 1'b1;
      mode = VEC[v][17:16];
      tick(2);
      load_word(VEC[v][15:0]);
      wait_ready();
      exp  = expect_frame(mode, VEC[v][15:0], n);
      mask = (n == 32) ? '1 : ((32'd1 << n) - 1);
      @(negedge clk); cs_n = 1'b0;
      if (mode[1]) begin
        self_capture(n, got, tok, seen);
        chk(seen == n && (got & mask) == exp, "R4 self-clocked frame", got, exp);
        chk(tok, "R5 sclk_out period 4, high 1", 32'(tok), 1);
        chk(sclk_oe == 1'b1, "R4 sclk_oe in self mode", 32'(sclk_oe), 1);
      end else begin
        tick(3);
        ext_capture(n, got);
        chk((got & mask) == exp, (mode == 2'b00) ? "R2 async frame" : "R3 sync frame",
            got, exp);
        chk(sclk_oe == 1'b0, "R11 sclk_oe off", 32'(sclk_oe), 0);
      end
      tick(4);
      chk(drdy_n == 1'b1 && sdata == 1'b1, "R7 release after last bit",
          {30'd0, drdy_n, sdata}, 32'd3);
    end

    // R8 blanking window, R6 waiting with cs high
    cs_n = 1'b1; mode = 2'b01; tick(2);
    load_word(16'hC0DE);
    for (int i = 0; i < 4; i++) begin
      chk(drdy_n == 1'b1, "R8 blank cycle", 32'(drdy_n), 1);
      tick(1);
    end
    chk(drdy_n == 1'b0, "R8 ready after blanking", 32'(drdy_n), 0);
    sclk_in = 1'b1; tick(6); sclk_in = 1'b0; tick(6);
    chk(drdy_n == 1'b0 && sdata == 1'b1, "R6 waits while deselected",
        {30'd0, drdy_n, sdata}, 32'd1);

    // R9 load and deselect in the same cycle mid-word
    cs_n = 1'b0; tick(3);
    ext_capture(3, got);
    @(negedge clk); load = 1'b1; load_data = 16'h3C96; cs_n = 1'b1;
    @(negedge clk); load = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(drdy_n == 1'b1 && sdata == 1'b1, "R9 reload blanking",
          {30'd0, drdy_n, sdata}, 32'd3);
      tick(1);
    end
    chk(drdy_n == 1'b0, "R9 new word ready", 32'(drdy_n), 0);
    cs_n = 1'b0; tick(3);
    ext_capture(16, got);
    exp = expect_frame(2'b01, 16'h3C96, n);
    chk(got[15:0] == exp[15:0], "R9 new word from first bit", got, exp);
    tick(4);
    chk(drdy_n == 1'b1, "R7 release after reload word", 32'(drdy_n), 1);

    // R10 abort mid-word
    cs_n = 1'b1; mode = 2'b00; tick(2);
    load_word(16'hBEEF);
    wait_ready();
    cs_n = 1'b0; tick(3);
    ext_capture(5, got);
    cs_n = 1'b1; tick(4);
    chk(drdy_n == 1'b1 && sdata == 1'b1, "R10 abort to idle",
        {30'd0, drdy_n, sdata}, 32'd3);
    cs_n = 1'b0; tick(10);
    ext_capture(2, got);
    chk(drdy_n == 1'b1 && got[1:0] == 2'b11, "R10 no restart without load",
        {29'd0, drdy_n, got[1:0]}, 32'd7);
    chk(sclk_out == 1'b0 && sclk_oe == 1'b0, "R11 no clock in async",
        {30'd0, sclk_out, sclk_oe}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule